// File: doc/BRIEF.md
# Indexed Miss Pattern Detector

This block learns how a stream of loaded index values maps onto the cache misses that follow them. It assumes each miss address has the form `base + (index << shift)`. When a stream reports its first index, the block allocates a detector entry tagged by the stream's ID. Each later miss then stores, for every candidate shift, the base address that this index would imply. Each stored set of bases fills one slot.

When the same stream reports a second index, the block compares later misses against the stored bases. Each miss is rebased by the second index under every shift. If any rebased value equals a stored base, the block has found the base and the shift. It reports them together with the stream ID, so that the owning stream can be switched to indirect prefetching.

Only one detector entry watches misses at any time. Entries live in a small fully associative table with least-recently-used replacement.

Top module: `idxpat_detector`

## Requirements
- R1: After reset, `foundValid` is low, and it stays low until a match is found.
- R2: An index for a stream ID that has no valid entry allocates an entry and stores the value as the first index. The entry is the lowest-numbered invalid entry if one exists, otherwise the least recently used one. The new entry becomes the sole miss tracker.
- R3: An index for a stream whose entry holds only a first index is stored as that entry's second index. That entry becomes the miss tracker again, whichever entry was tracking before.
- R4: An index for a stream whose entry already holds a second index invalidates the entry and stops miss tracking. The next index from that stream starts over as a first index.
- R5: While the tracked entry holds only a first index, each miss stores `missAddr - (idx1 << s)` for every configured shift `s` into the next free slot. Tracking stops once all `SLOTS` slots are filled, and later misses store nothing.
- R6: While the tracked entry holds a second index, each miss compares `missAddr - (idx2 << s)` with the stored base of every filled slot under the same shift. On a match, `foundValid` is high for exactly one cycle, in the cycle after the miss. `foundStream`, `foundBase` and `foundShift` carry the entry's stream ID, the matching base and that shift's value.
- R7: After a match the entry is invalidated and tracking stops. A repeat of the same miss reports nothing, and the next index from that stream is treated as a first index.
- R8: Misses update only the single tracked entry. An entry that is no longer the tracker gains no slots.
- R9: When an index and a miss arrive in the same cycle, the index is processed and the miss is dropped.
- R10: When several slot/shift pairs match, the lowest slot wins. Within a slot, the shift listed first in `SHIFT_LIST` wins (defaults 2, 3, 4).
- R11: Each index event makes its entry the most recently used. With every entry valid, a new stream replaces the least recently used entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| idxValid | input | 1 | An index value was read by a stream |
| idxStream | input | SID_W | Stream-entry ID of that index |
| idxValue | input | IDX_W | Index value, unsigned |
| missValid | input | 1 | A cache miss occurred |
| missAddr | input | ADDR_W | Miss address |
| foundValid | output | 1 | One-cycle pulse: a pattern was found |
| foundStream | output | SID_W | Stream ID owning the pattern |
| foundBase | output | ADDR_W | Detected base address |
| foundShift | output | $clog2(ADDR_W) | Detected shift amount |

## Verification
Index and miss events take effect at the clock edge that samples them. A miss that completes a match therefore shows up on `foundValid` and the found fields right after that same edge, and the pulse is gone one edge later. The bench drives every event at a falling edge and waits for the next rising edge. It then checks the found outputs at the following falling edge, and checks one idle cycle later that the pulse has dropped. Effects that leave no direct output are observed through a later matching miss: dropped misses, evicted entries and invalidated entries each show up as a report or its absence.

// File: rtl/idxpat_pkg.sv
package idxpat_pkg;

  // Strobes issued by the control to the entry datapath for one cycle.
  typedef struct packed {
    logic alloc;      // write tag and first index into entrySel
    logic setSecond;  // write second index into entrySel
    logic drop;       // invalidate entrySel
    logic record;     // store candidate bases into tracked entry
    logic report;     // publish match and invalidate tracked entry
  } idxpatStrobe_t;

endpackage

// File: rtl/idxpat_datapath.sv
module idxpat_datapath
  import idxpat_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 16,
  parameter int SID_W   = 4,
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 4,
  parameter int NSHIFT  = 3,
  parameter int SHIFT_LIST [NSHIFT] = '{2, 3, 4},
  localparam int EW  = $clog2(ENTRIES),
  localparam int CW  = $clog2(SLOTS + 1),
  localparam int SW  = $clog2(SLOTS),
  localparam int SHW = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  idxpatStrobe_t     strb,
  input  logic [EW-1:0]     entrySel,
  input  logic [EW-1:0]     trackSel,
  input  logic [SID_W-1:0]  idxStream,
  input  logic [IDX_W-1:0]  idxValue,
  input  logic [ADDR_W-1:0] missAddr,
  output logic [ENTRIES-1:0] hitVec,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] secondVec,
  output logic [CW-1:0]     trackCount,
  output logic              matchAny,
  output logic              foundValid,
  output logic [SID_W-1:0]  foundStream,
  output logic [ADDR_W-1:0] foundBase,
  output logic [SHW-1:0]    foundShift
);

  logic [ENTRIES-1:0] entValid, entSecond;
  logic [SID_W-1:0]   entTag  [ENTRIES];
  logic [IDX_W-1:0]   entIdx1 [ENTRIES];
  logic [IDX_W-1:0]   entIdx2 [ENTRIES];
  logic [CW-1:0]      entCnt  [ENTRIES];
  logic [ADDR_W-1:0]  entBase [ENTRIES][SLOTS][NSHIFT];

  logic [ADDR_W-1:0]  cand  [NSHIFT];
  logic [ADDR_W-1:0]  probe [NSHIFT];
  logic [ADDR_W-1:0]  matchBase;
  logic [SHW-1:0]     matchShift;
  logic [SW-1:0]      slotPtr;

  assign validVec   = entValid;
  assign secondVec  = entSecond;
  assign trackCount = entCnt[trackSel];
  assign slotPtr    = entCnt[trackSel][SW-1:0];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_hit
    assign hitVec[e] = entValid[e] && (entTag[e] == idxStream);
  end

  // Bases implied by the first index (record) and probes by the second.
  for (genvar k = 0; k < NSHIFT; k++) begin : g_shift
    assign cand[k]  = missAddr - (ADDR_W'(entIdx1[trackSel]) << SHIFT_LIST[k]);
    assign probe[k] = missAddr - (ADDR_W'(entIdx2[trackSel]) << SHIFT_LIST[k]);
  end

  // Full parallel compare; first hit in slot-then-shift order wins.
  always_comb begin
    logic hit;
    hit        = 1'b0;
    matchBase  = '0;
    matchShift = '0;
    for (int j = 0; j < SLOTS; j++) begin
      for (int k = 0; k < NSHIFT; k++) begin
        if (!hit && (CW'(j) < entCnt[trackSel]) &&
            (entBase[trackSel][j][k] == probe[k])) begin
          hit        = 1'b1;
          matchBase  = entBase[trackSel][j][k];
          matchShift = SHW'(SHIFT_LIST[k]);
        end
      end
    end
    matchAny = hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entValid    <= '0;
      entSecond   <= '0;
      foundValid  <= 1'b0;
      foundStream <= '0;
      foundBase   <= '0;
      foundShift  <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        entCnt[e]  <= '0;
        entTag[e]  <= '0;
        entIdx1[e] <= '0;
        entIdx2[e] <= '0;
      end
    end else begin
      foundValid <= 1'b0;
      if (strb.alloc) begin
        entValid[entrySel]  <= 1'b1;
        entSecond[entrySel] <= 1'b0;
        entTag[entrySel]    <= idxStream;
        entIdx1[entrySel]   <= idxValue;
        entCnt[entrySel]    <= '0;
      end
      if (strb.setSecond) begin
        entIdx2[entrySel]   <= idxValue;
        entSecond[entrySel] <= 1'b1;
      end
      if (strb.drop) entValid[entrySel] <= 1'b0;
      if (strb.record) entCnt[trackSel] <= entCnt[trackSel] + CW'(1);
      if (strb.report) begin
        entValid[trackSel] <= 1'b0;
        foundValid         <= 1'b1;
        foundStream        <= entTag[trackSel];
        foundBase          <= matchBase;
        foundShift         <= matchShift;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.record) begin
      for (int k = 0; k < NSHIFT; k++) entBase[trackSel][slotPtr][k] <= cand[k];
    end
  end

  // R5
  slot_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.record |-> (entCnt[trackSel] < CW'(SLOTS)));
  // R6
  report_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.report |=> foundValid);
  // R6
  found_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    foundValid |=> !foundValid);
  // R7
  released_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.report |=> !entValid[$past(trackSel)]);

endmodule

// File: rtl/idxpat_ctrl.sv
module idxpat_ctrl
  import idxpat_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 4,
  localparam int EW = $clog2(ENTRIES),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idxValid,
  input  logic               missValid,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] secondVec,
  input  logic [CW-1:0]      trackCount,
  input  logic               matchAny,
  output idxpatStrobe_t      strb,
  output logic [EW-1:0]      entrySel,
  output logic [EW-1:0]      trackSel
);

  logic          trackValid, nextTrackValid;
  logic [EW-1:0] trackPtr, nextTrackPtr;
  logic [EW-1:0] age [ENTRIES];
  logic          hitAny;
  logic [EW-1:0] hitIdx, victim;
  logic          touchEn;
  logic [EW-1:0] touchIdx;
  logic [ENTRIES-1:0] oldestVec;

  assign trackSel = trackPtr;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_old
    assign oldestVec[e] = (age[e] == EW'(ENTRIES - 1));
  end

  // Lookup and replacement choice.
  always_comb begin
    logic freeSeen;
    hitAny   = |hitVec;
    hitIdx   = '0;
    victim   = '0;
    freeSeen = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hitVec[e]) hitIdx = EW'(e);
      if (oldestVec[e] && !freeSeen) victim = EW'(e);
    end
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!validVec[e]) begin
        victim   = EW'(e);
        freeSeen = 1'b1;
      end
    end
  end

  always_comb begin
    strb           = '0;
    entrySel       = hitIdx;
    touchEn        = 1'b0;
    touchIdx       = hitIdx;
    nextTrackValid = trackValid;
    nextTrackPtr   = trackPtr;
    if (idxValid) begin
      touchEn = 1'b1;
      if (hitAny) begin
        if (!secondVec[hitIdx]) begin
          strb.setSecond = 1'b1;
          nextTrackValid = 1'b1;
          nextTrackPtr   = hitIdx;
        end else begin
          strb.drop      = 1'b1;
          nextTrackValid = 1'b0;
        end
      end else begin
        strb.alloc     = 1'b1;
        entrySel       = victim;
        touchIdx       = victim;
        nextTrackValid = 1'b1;
        nextTrackPtr   = victim;
      end
    end else if (missValid && trackValid) begin
      if (!secondVec[trackPtr]) begin
        strb.record = 1'b1;
        if (trackCount == CW'(SLOTS - 1)) nextTrackValid = 1'b0;
      end else if (matchAny) begin
        strb.report    = 1'b1;
        nextTrackValid = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trackValid <= 1'b0;
      trackPtr   <= '0;
      for (int e = 0; e < ENTRIES; e++) age[e] <= EW'(e);
    end else begin
      trackValid <= nextTrackValid;
      trackPtr   <= nextTrackPtr;
      if (touchEn) begin
        for (int e = 0; e < ENTRIES; e++) begin
          if (EW'(e) == touchIdx) age[e] <= '0;
          else if (age[e] < age[touchIdx]) age[e] <= age[e] + EW'(1);
        end
      end
    end
  end

  // R2
  alloc_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.alloc |=> (trackValid && trackPtr == $past(entrySel)));
  // R3
  second_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setSecond |=> (trackValid && trackPtr == $past(entrySel)));
  // R4
  drop_untracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.drop |=> !trackValid);
  // R11
  single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldestVec) == 1);
  // R9
  index_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idxValid |-> !(strb.record || strb.report));

endmodule

// File: rtl/idxpat_detector.sv
module idxpat_detector
  import idxpat_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 16,
  parameter int SID_W   = 4,
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 4,
  parameter int NSHIFT  = 3,
  parameter int SHIFT_LIST [NSHIFT] = '{2, 3, 4},
  localparam int EW  = $clog2(ENTRIES),
  localparam int CW  = $clog2(SLOTS + 1),
  localparam int SHW = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idxValid,
  input  logic [SID_W-1:0]  idxStream,
  input  logic [IDX_W-1:0]  idxValue,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              foundValid,
  output logic [SID_W-1:0]  foundStream,
  output logic [ADDR_W-1:0] foundBase,
  output logic [SHW-1:0]    foundShift
);

  idxpatStrobe_t      strb;
  logic [EW-1:0]      entrySel, trackSel;
  logic [ENTRIES-1:0] hitVec, validVec, secondVec;
  logic [CW-1:0]      trackCount;
  logic               matchAny;

  idxpat_ctrl #(.ENTRIES(ENTRIES), .SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .idxValid(idxValid), .missValid(missValid),
    .hitVec(hitVec), .validVec(validVec), .secondVec(secondVec),
    .trackCount(trackCount), .matchAny(matchAny),
    .strb(strb), .entrySel(entrySel), .trackSel(trackSel)
  );

  idxpat_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SID_W(SID_W), .ENTRIES(ENTRIES),
    .SLOTS(SLOTS), .NSHIFT(NSHIFT), .SHIFT_LIST(SHIFT_LIST)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .entrySel(entrySel),
    .trackSel(trackSel), .idxStream(idxStream), .idxValue(idxValue),
    .missAddr(missAddr), .hitVec(hitVec), .validVec(validVec),
    .secondVec(secondVec), .trackCount(trackCount), .matchAny(matchAny),
    .foundValid(foundValid), .foundStream(foundStream),
    .foundBase(foundBase), .foundShift(foundShift)
  );

endmodule

// File: tb/idxpat_detector_bench.sv
module idxpat_detector_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idxValid = 1'b0;
  logic [3:0]  idxStream = '0;
  logic [15:0] idxValue = '0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        foundValid;
  logic [3:0]  foundStream;
  logic [31:0] foundBase;
  logic [4:0]  foundShift;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  idxpat_detector u_idxpat_detector (
    .clk(clk), .rst_n(rst_n), .idxValid(idxValid), .idxStream(idxStream),
    .idxValue(idxValue), .missValid(missValid), .missAddr(missAddr),
    .foundValid(foundValid), .foundStream(foundStream),
    .foundBase(foundBase), .foundShift(foundShift)
  );

  // All drive tasks start and end at a falling edge.
  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
    idxValid  = 1'b0;
    missValid = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sendIdx(input logic [3:0] s, input logic [15:0] v);
    idxValid = 1'b1; idxStream = s; idxValue = v;
    stepCycle();
  endtask

  task automatic sendMiss(input logic [31:0] a);
    missValid = 1'b1; missAddr = a;
    stepCycle();
  endtask

  task automatic expectFound(input string req, input bit expV,
                             input logic [3:0] expS, input logic [31:0] expB,
                             input logic [4:0] expSh);
    checks++;
    if (foundValid !== expV ||
        (expV && (foundStream !== expS || foundBase !== expB || foundShift !== expSh))) begin
      errors++;
      $display("FAIL %s: got v=%0b s=%0d base=%h sh=%0d, expected v=%0b s=%0d base=%h sh=%0d",
               req, foundValid, foundStream, foundBase, foundShift,
               expV, expS, expB, expSh);
    end
  endtask

  task automatic testReset();
    doReset();
    expectFound("R1 reset", 1'b0, '0, '0, '0);
    stepCycle();
    expectFound("R1 idle", 1'b0, '0, '0, '0);
  endtask

  task automatic testBasicAndRelease();
    doReset();
    sendIdx(4'd3, 16'd10);
    sendMiss(32'h1050);
    sendMiss(32'h2222);
    sendIdx(4'd3, 16'd20);
    sendMiss(32'h10A0);
    expectFound("R6 basic match", 1'b1, 4'd3, 32'h1000, 5'd3);
    stepCycle();
    expectFound("R6 pulse ends", 1'b0, '0, '0, '0);
    sendMiss(32'h10A0);
    expectFound("R7 no report after release", 1'b0, '0, '0, '0);
    sendIdx(4'd3, 16'd10);
    sendMiss(32'h1050);
    sendIdx(4'd3, 16'd20);
    sendMiss(32'h10A0);
    expectFound("R7 restart as first index", 1'b1, 4'd3, 32'h1000, 5'd3);
  endtask

  task automatic testThirdIndex();
    doReset();
    sendIdx(4'd5, 16'd1);
    sendMiss(32'h0C00);
    sendIdx(4'd5, 16'd2);
    sendMiss(32'h0D00);
    expectFound("R6 unrelated miss", 1'b0, '0, '0, '0);
    sendIdx(4'd5, 16'd3);
    sendIdx(4'd5, 16'd1);
    sendMiss(32'h0C00);
    sendIdx(4'd5, 16'd2);
    sendMiss(32'h0C04);
    expectFound("R4 third index restarts", 1'b1, 4'd5, 32'h0BFC, 5'd2);
  endtask

  task automatic testSlotLimit();
    doReset();
    sendIdx(4'd6, 16'd1);
    for (int i = 0; i < 5; i++) sendMiss(32'h4000 + 32'(i) * 32'h1000);
    sendIdx(4'd6, 16'd2);
    sendMiss(32'h8004);
    expectFound("R5 fifth miss not stored", 1'b0, '0, '0, '0);
    sendMiss(32'h7004);
    expectFound("R5 last slot stored", 1'b1, 4'd6, 32'h6FFC, 5'd2);
  endtask

  task automatic testPriority();
    doReset();
    sendIdx(4'd9, 16'd1);
    sendMiss(32'h0300);
    sendMiss(32'h0304);
    sendIdx(4'd9, 16'd2);
    sendMiss(32'h0308);
    expectFound("R10 lowest slot wins", 1'b1, 4'd9, 32'h02F8, 5'd3);
    doReset();
    sendIdx(4'd9, 16'd0);
    sendMiss(32'h0500);
    sendIdx(4'd9, 16'd0);
    sendMiss(32'h0500);
    expectFound("R10 first listed shift wins", 1'b1, 4'd9, 32'h0500, 5'd2);
  endtask

  task automatic testSingleTracker();
    doReset();
    sendIdx(4'd1, 16'd1);
    sendIdx(4'd2, 16'd1);
    sendMiss(32'h0900);
    sendIdx(4'd1, 16'd2);
    sendMiss(32'h0904);
    expectFound("R8 untracked entry has no slots", 1'b0, '0, '0, '0);
    sendIdx(4'd2, 16'd2);
    sendMiss(32'h0904);
    expectFound("R3 second index retakes tracking", 1'b1, 4'd2, 32'h08FC, 5'd2);
  endtask

  task automatic testSameCycle();
    doReset();
    idxValid = 1'b1; idxStream = 4'd8; idxValue = 16'd1;
    missValid = 1'b1; missAddr = 32'h0A00;
    stepCycle();
    sendIdx(4'd8, 16'd2);
    sendMiss(32'h0A04);
    expectFound("R9 concurrent miss dropped", 1'b0, '0, '0, '0);
  endtask

  task automatic testLru();
    doReset();
    sendIdx(4'd1, 16'd1);
    sendIdx(4'd2, 16'd1);
    sendIdx(4'd3, 16'd1);
    sendIdx(4'd4, 16'd1);
    sendIdx(4'd1, 16'd2);
    sendIdx(4'd7, 16'd1);
    // Stream 2 was least recently used and must have been replaced (R2, R11).
    sendIdx(4'd2, 16'd1);
    sendMiss(32'h0B00);
    sendIdx(4'd2, 16'd2);
    sendMiss(32'h0B04);
    expectFound("R11 LRU entry replaced", 1'b1, 4'd2, 32'h0AFC, 5'd2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testBasicAndRelease();
    testThirdIndex();
    testSlotLimit();
    testPriority();
    testSingleTracker();
    testSameCycle();
    testLru();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule